// File: doc/BRIEF.md
# Page-Mode Read Access Tracker

This block sits behind the control pins of an asynchronous SRAM-style read port and sorts every read into one of two classes: a full random access, which costs the long latency and fetches a whole 8-word line from the backing array, or a page hit, which is served from the line already held and costs only the short latency. The pins (chip-select, output-enable, word address) are sampled on the block clock. A busy flag marks the cycles in which an access is still counting, and a valid flag rises when the counted latency has elapsed, with the selected word on the read-data port.

A page is the aligned group of 8 words that share every address bit from bit 3 upward. Once a line is fetched, the three lowest address bits may walk through the page in any order, starting at any word, forward or backward. Changing any upper address bit, or deasserting chip-select, closes the page, so the next read is a full access again. No setup is needed: plain random reads work through the same path.

Both latencies are parameters counted in clock cycles. The backing array is a synchronous memory outside the block: the block raises a one-cycle line request with the line address, and captures the returned line two clock edges after the request edge.

Top module: `pm_read_tracker`

## Requirements
- R1: After reset, busy, valid, line_req and rdata are all zero.
- R2: A read (cs_n low, oe_n low) with no open page raises line_req for the first cycle, with line_addr equal to address bits [21:3], and valid rises on the FULL_CYC-th clock edge, counting the sampling edge as the first.
- R3: A read to a new word of the open page, made when no full access is still counting, raises no line_req, sets page_hit, and raises valid on the PAGE_CYC-th edge.
- R4: When valid is high, rdata is the word addressed by the current address; the three lowest bits pick the word and may take any value in any order.
- R5: A read whose address bits [21:3] differ from the open page is a full access as in R2.
- R6: Sampling cs_n high closes the page and clears busy and valid on the next edge; the next read is a full access.
- R7: A change of address bits [2:0] while an access is still counting restarts that access's counter from the change edge with the same kind, and a restarted full access issues no second line request.
- R8: Sampling oe_n high while cs_n is low ends the current access (busy and valid low) but keeps the page open, so a following read in the same page is a page hit.
- R9: While the same address stays on the pins with both selects low, valid and rdata hold; when valid is low, rdata is zero.
- R10: busy and valid are never high together, and page_hit is high only for an access that is a page hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| oe_n | input | 1 | Output-enable, active low |
| addr | input | 22 | Word address |
| line_data | input | 128 | Line returned by the backing array, word i at bits [16i+15:16i] |
| line_req | output | 1 | One-cycle line fetch request |
| line_addr | output | 19 | Line address for the fetch |
| busy | output | 1 | Access latency still counting |
| valid | output | 1 | Read data valid |
| page_hit | output | 1 | Current access is a page hit |
| rdata | output | 16 | Selected word, zero when not valid |

## Verification
The hardest case to reach from the pins is a low-address change landing while an access is still counting, because it must hit a cycle between the sampling edge and the valid edge, and the two counter kinds react differently. The bench drives inputs on the falling edge and counts rising edges from the start of each access, so it can move the low address bits after a chosen number of edges inside a full access and inside a page hit, then check the restarted latency, the absence of a second fetch and the returned word.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic {
        KIND_FULL = 1'b0,
        KIND_PAGE = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/pm_page_cmp.sv
module pm_page_cmp #(
    parameter int ADDR_W = 22,
    parameter int PAGE_W = 3
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [ADDR_W-PAGE_W-1:0] tag,
    output logic                     same_addr,
    output logic                     upper_eq
);

    assign same_addr = (addr == acc_addr);
    assign upper_eq  = (addr[ADDR_W-1:PAGE_W] == tag);

endmodule

// File: rtl/pm_line_buf.sv
module pm_line_buf #(
    parameter int DATA_W = 16,
    parameter int PAGE_W = 3,
    localparam int WORDS  = 1 << PAGE_W,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    input  logic [PAGE_W-1:0] idx,
    input  logic              en,
    output logic [DATA_W-1:0] word_out
);

    logic [DATA_W-1:0] slot_q [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_slot
        logic [DATA_W-1:0] slot_d;

        always_comb begin
            slot_d = slot_q[gi];
            if (load) begin
                slot_d = line_in[gi*DATA_W +: DATA_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else begin
                slot_q[gi] <= slot_d;
            end
        end
    end

    assign word_out = en ? slot_q[idx] : '0;

endmodule

// File: rtl/pm_read_tracker.sv
module pm_read_tracker #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int PAGE_W   = 3,
    parameter int FULL_CYC = 6,
    parameter int PAGE_CYC = 2,
    localparam int WORDS   = 1 << PAGE_W,
    localparam int LINE_W  = DATA_W * WORDS,
    localparam int TAG_W   = ADDR_W - PAGE_W,
    localparam int MAX_LAT = (FULL_CYC > PAGE_CYC) ? FULL_CYC : PAGE_CYC,
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] line_data,
    output logic              line_req,
    output logic [TAG_W-1:0]  line_addr,
    output logic              busy,
    output logic              valid,
    output logic              page_hit,
    output logic [DATA_W-1:0] rdata
);

    import pm_pkg::*;

    localparam logic [CNT_W-1:0] FULL_LOAD = CNT_W'(FULL_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic              valid;
        acc_kind_e         kind;
        logic              page_open;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] acc_addr;
        logic [CNT_W-1:0]  cnt;
        logic              line_req;
        logic              fill;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       same_addr;
    logic       upper_eq;
    logic       rd_req;
    acc_kind_e  new_kind;

    pm_page_cmp #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) cmp_i (
        .addr      (addr),
        .acc_addr  (st_q.acc_addr),
        .tag       (st_q.tag),
        .same_addr (same_addr),
        .upper_eq  (upper_eq)
    );

    pm_line_buf #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q.fill),
        .line_in  (line_data),
        .idx      (st_q.acc_addr[PAGE_W-1:0]),
        .en       (st_q.valid),
        .word_out (rdata)
    );

    assign rd_req = !cs_n && !oe_n;

    // Kind of an access that starts this cycle.
    always_comb begin
        if (!st_q.page_open || !upper_eq) begin
            new_kind = KIND_FULL;
        end else if (st_q.busy && st_q.kind == KIND_FULL) begin
            new_kind = KIND_FULL;
        end else begin
            new_kind = KIND_PAGE;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.line_req = 1'b0;
        st_d.fill     = st_q.line_req;

        if (cs_n) begin
            st_d.busy      = 1'b0;
            st_d.valid     = 1'b0;
            st_d.page_open = 1'b0;
            st_d.fill      = 1'b0;
        end else if (!rd_req) begin
            st_d.busy  = 1'b0;
            st_d.valid = 1'b0;
        end else if ((st_q.busy || st_q.valid) && same_addr) begin
            if (st_q.busy) begin
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.busy  = 1'b0;
                    st_d.valid = 1'b1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end else begin
            st_d.acc_addr = addr;
            st_d.kind     = new_kind;
            if (!st_q.page_open || !upper_eq) begin
                st_d.line_req  = 1'b1;
                st_d.tag       = addr[ADDR_W-1:PAGE_W];
                st_d.page_open = 1'b1;
            end
            st_d.cnt   = (new_kind == KIND_FULL) ? FULL_LOAD : PAGE_LOAD;
            st_d.busy  = (st_d.cnt != '0);
            st_d.valid = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_req  = st_q.line_req;
    assign line_addr = st_q.tag;
    assign busy      = st_q.busy;
    assign valid     = st_q.valid;
    assign page_hit  = (st_q.kind == KIND_PAGE) && (st_q.busy || st_q.valid);

endmodule

// File: rtl/pm_read_tracker_chk.sv
module pm_read_tracker_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              line_req,
    input logic              busy,
    input logic              valid,
    input logic              page_hit,
    input logic [DATA_W-1:0] rdata
);

    a_r10_busy_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && valid));

    a_r2_req_is_full: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> (busy && !page_hit));

    a_r3_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        page_hit |-> !line_req);

    a_r6_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!busy && !valid));

    a_r8_oe_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && oe_n) |=> (!busy && !valid));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (rdata == '0));

endmodule

bind pm_read_tracker pm_read_tracker_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .line_req (line_req),
    .busy     (busy),
    .valid    (valid),
    .page_hit (page_hit),
    .rdata    (rdata)
);

// File: tb/pm_read_tracker_tb_top.sv
module pm_read_tracker_tb_top;

    localparam int FULL_CYC = 6;
    localparam int PAGE_CYC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         oe_n = 1'b1;
    logic [21:0]  addr = '0;
    logic [127:0] line_data = '0;
    logic         line_req;
    logic [18:0]  line_addr;
    logic         busy;
    logic         valid;
    logic         page_hit;
    logic [15:0]  rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pm_read_tracker #(
        .FULL_CYC (FULL_CYC),
        .PAGE_CYC (PAGE_CYC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .line_data (line_data),
        .line_req  (line_req),
        .line_addr (line_addr),
        .busy      (busy),
        .valid     (valid),
        .page_hit  (page_hit),
        .rdata     (rdata)
    );

    function automatic logic [15:0] word_of(input logic [21:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Backing array: synchronous, one line per request.
    always_ff @(posedge clk) begin
        if (line_req) begin
            for (int i = 0; i < 8; i++) begin
                line_data[i*16 +: 16] <= word_of({line_addr, 3'(i)});
            end
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // brk: 0 none, 1 oe_n high one cycle, 2 cs_n high one cycle
    task automatic do_break(input int brk);
        if (brk != 0) begin
            @(negedge clk);
            oe_n = 1'b1;
            if (brk == 2) cs_n = 1'b1;
            @(posedge clk);
            #1;
            check(!busy && !valid, (brk == 2) ? "R6 cs ends access" : "R8 oe ends access",
                  {busy, valid}, 0);
        end
    endtask

    // Drive a read and count edges until valid.
    task automatic read_acc(input logic [21:0] a, input logic full, input string req);
        int n;
        @(negedge clk);
        cs_n = 1'b0;
        oe_n = 1'b0;
        addr = a;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
            if (n == 1) begin
                check(line_req == full, {req, " line_req"}, line_req, full);
                if (full) check(line_addr == a[21:3], "R2 line_addr", line_addr, a[21:3]);
            end
        end while (!valid && n < 40);
        check(n == (full ? FULL_CYC : PAGE_CYC), {req, " latency"}, n, full ? FULL_CYC : PAGE_CYC);
        check(rdata == word_of(a), "R4 word", rdata, word_of(a));
        check(page_hit == !full, "R10 page_hit", page_hit, !full);
    endtask

    // {brk[1:0], full, addr[21:0]}
    localparam logic [24:0] VEC [10] = '{
        {2'd2, 1'b1, 22'h000123},
        {2'd0, 1'b0, 22'h000125},
        {2'd0, 1'b0, 22'h000120},
        {2'd1, 1'b0, 22'h000127},
        {2'd0, 1'b1, 22'h000133},
        {2'd2, 1'b1, 22'h000131},
        {2'd1, 1'b0, 22'h000136},
        {2'd0, 1'b1, 22'h3FFFF8},
        {2'd0, 1'b0, 22'h3FFFFF},
        {2'd1, 1'b0, 22'h3FFFF9}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!busy && !valid && !line_req && rdata == 0, "R1 reset state",
              {busy, valid, line_req, rdata}, 0);

        // R2 R3 R5 R6 R8: table walk
        foreach (VEC[k]) begin
            do_break(int'(VEC[k][24:23]));
            read_acc(VEC[k][21:0], VEC[k][22], VEC[k][22] ? "R2/R5 full" : "R3 hit");
        end

        // R9: hold same address, then idle output is zero
        repeat (3) @(posedge clk);
        #1;
        check(valid && rdata == word_of(22'h3FFFF9), "R9 hold", rdata, word_of(22'h3FFFF9));
        @(negedge clk);
        oe_n = 1'b1;
        @(posedge clk);
        #1;
        check(!valid && rdata == 0, "R9 idle zero", rdata, 0);

        // R7: restart during a full access
        do_break(2);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; addr = 22'h0004A1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 22'h0004A6;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
            if (n == 1) check(!line_req, "R7 no refetch", line_req, 0);
        end while (!valid && n < 40);
        check(n == FULL_CYC, "R7 full restart latency", n, FULL_CYC);
        check(rdata == word_of(22'h0004A6), "R7 full restart word", rdata, word_of(22'h0004A6));

        // R7: restart during a page hit
        do_break(1);
        @(negedge clk);
        oe_n = 1'b0; addr = 22'h0004A2;
        @(posedge clk);
        @(negedge clk);
        addr = 22'h0004A4;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!valid && n < 40);
        check(n == PAGE_CYC, "R7 page restart latency", n, PAGE_CYC);
        check(page_hit && rdata == word_of(22'h0004A4), "R7 page restart word",
              rdata, word_of(22'h0004A4));

        // R6: after chip-select high, same page is a full access again
        do_break(2);
        read_acc(22'h0004A0, 1'b1, "R6 reopen full");

        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule